// File: doc/BRIEF.md
# Interrupt Priority Resolver with Promotion

This block decides which interrupt source the processor core serves next. It has eighteen sources. Three of them are non-maskable request lines: a reset request, an illegal-opcode trap and an external non-maskable pin. Fifteen are peripheral sources. Each peripheral source has a status flag. A one-cycle event pulse from the peripheral sets the flag, and the flag stays set until software clears it. While the global mask input is clear, a set flag counts as a pending maskable request.

The outputs are combinational and are valid in the same cycle as the state that produces them: a valid bit, the index of the winning source and the two-byte vector address the core fetches for that source. The non-maskable sources always win over the maskable ones. The maskable sources follow a fixed default order. A promotion register can lift any one maskable source above all the other maskable sources. Software can write the promotion register only while the global mask is set. Software uses the same write port, at a second address, to clear flags.

Top module: `irq_resolver`

## Requirements
- R1: Source indices 0, 1 and 2 are the non-maskable sources: reset request, illegal-opcode trap and external non-maskable pin. When any `nmi_req_i` bit is set, the winner is the lowest set bit, whatever the state of `irq_mask_i`.
- R2: While `irq_mask_i` is 1 and no non-maskable request is present, `valid_o` is 0, even if flags are set.
- R3: When no non-maskable request is present and `irq_mask_i` is 0, the winner among the pending maskable sources is the one with the lowest maskable number m. Maskable number m has global index 3+m.
- R4: The promotion register holds a maskable number. If that source's flag is set and maskable requests are recognised, it wins over every other maskable source.
- R5: If the promoted source is not pending, arbitration uses the default order of R3.
- R6: A write with `wr_addr_i`=0 loads the promotion register from `wr_data_i[3:0]`. The write takes effect only when `irq_mask_i` is 1 and the code is below 15. A write made while the mask is clear, or with code 15, leaves the register unchanged.
- R7: Flag m becomes 1 on the clock edge after `evt_i[m]` is 1. It stays 1 until a write with `wr_addr_i`=1 and `wr_data_i[m]`=1 (write one to clear). If a set and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R8: While `valid_o` is 1, `vec_o` equals 0xFFFE minus twice the winning index. Reset therefore uses 0xFFFE/0xFFFF, and each lower-priority source uses the next lower pair.
- R9: After reset all flags are 0 and the promotion register holds code 0. Code 0 names the source that already leads the default order.
- R10: When no request is recognised, `valid_o`, `idx_o` and `vec_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req_i | input | 3 | Non-maskable request lines, bit 0 highest priority |
| evt_i | input | 15 | Peripheral event pulses that set the flags |
| irq_mask_i | input | 1 | Global interrupt mask, 1 = maskable requests blocked |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = promotion register, 1 = flag clear |
| wr_data_i | input | 15 | Write data |
| flags_o | output | 15 | Current peripheral status flags |
| valid_o | output | 1 | A source is selected |
| idx_o | output | 5 | Index of the selected source |
| vec_o | output | 16 | Vector address for the selected source |

## Verification
The promotion register has no read path, so its contents can only be inferred from who wins arbitration. The hardest case is showing that a rejected write changed nothing. The bench first promotes one source while the mask is set. It then attempts a write while the mask is clear, and another with the out-of-range code, after arranging the pending flags so that each attempted code would pick a different winner if it had been accepted. Reading the winner index after each attempt shows whether the register kept its value.

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N_NMI   = 3,
  parameter int N_MSK   = 15,
  parameter int AW      = 16,
  parameter int VEC_TOP = 'hFFFE,
  localparam int N_SRC  = N_NMI + N_MSK,
  localparam int IW     = $clog2(N_SRC),
  localparam int SW     = $clog2(N_MSK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_NMI-1:0] nmi_req_i,
  input  logic [N_MSK-1:0] evt_i,
  input  logic             irq_mask_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [N_MSK-1:0] wr_data_i,
  output logic [N_MSK-1:0] flags_o,
  output logic             valid_o,
  output logic [IW-1:0]    idx_o,
  output logic [AW-1:0]    vec_o
);

  logic [N_MSK-1:0] flags_q;
  logic [N_MSK-1:0] clr_vec;
  logic [N_MSK-1:0] msk_req;
  logic [N_SRC-1:0] all_req;
  logic [SW-1:0]    sel_q;
  logic [IW-1:0]    win;
  logic             hit;
  logic             sel_wr;
  logic             nmi_any;

  assign clr_vec = (wr_en_i && wr_addr_i) ? wr_data_i : '0;
  assign sel_wr  = wr_en_i && !wr_addr_i && irq_mask_i &&
                   ({1'b0, wr_data_i[SW-1:0]} < (SW+1)'(N_MSK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      sel_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | evt_i;
      if (sel_wr) sel_q <= wr_data_i[SW-1:0];
    end
  end

  assign msk_req = flags_q & {N_MSK{~irq_mask_i}};
  assign all_req = {msk_req, nmi_req_i};
  assign nmi_any = |nmi_req_i;

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (all_req[i]) begin
        hit = 1'b1;
        win = IW'(i);
      end
    end
    if (!nmi_any && msk_req[sel_q]) win = IW'(N_NMI) + IW'(sel_q);
  end

  assign flags_o = flags_q;
  assign valid_o = hit;
  assign idx_o   = win;
  assign vec_o   = hit ? (AW'(VEC_TOP) - (AW'(win) << 1)) : '0;

endmodule

module irq_resolver_chk #(
  parameter int N_NMI = 3,
  parameter int N_MSK = 15,
  parameter int IW    = 5,
  parameter int AW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_NMI-1:0] nmi_req_i,
  input logic             irq_mask_i,
  input logic             wr_en_i,
  input logic             wr_addr_i,
  input logic [N_MSK-1:0] wr_data_i,
  input logic [N_MSK-1:0] flags_o,
  input logic             valid_o,
  input logic [IW-1:0]    idx_o,
  input logic [AW-1:0]    vec_o
);

  logic [N_MSK-1:0] clr_c;
  logic             win_req;

  assign clr_c = (wr_en_i && wr_addr_i) ? wr_data_i : '0;

  always_comb begin
    win_req = 1'b0;
    if (int'(idx_o) < N_NMI) win_req = nmi_req_i[int'(idx_o)];
    else if (int'(idx_o) < N_NMI + N_MSK) win_req = flags_o[int'(idx_o) - N_NMI];
  end

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|nmi_req_i) |-> (valid_o && int'(idx_o) < N_NMI)); // R1

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask_i && !(|nmi_req_i)) |-> !valid_o); // R2

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> win_req); // R3

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(flags_o) & ~$past(clr_c)) & ~flags_o) == '0)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (idx_o == '0 && vec_o == '0)); // R10

endmodule

bind irq_resolver irq_resolver_chk #(
  .N_NMI(N_NMI), .N_MSK(N_MSK), .IW(IW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi_req_i), .irq_mask_i(irq_mask_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .flags_o(flags_o), .valid_o(valid_o), .idx_o(idx_o), .vec_o(vec_o)
);

// File: tb/irq_resolver_bench.sv
`timescale 1ns/1ps
module irq_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  nmi_req_i = '0;
  logic [14:0] evt_i = '0;
  logic        irq_mask_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        wr_addr_i = 1'b0;
  logic [14:0] wr_data_i = '0;
  logic [14:0] flags_o;
  logic        valid_o;
  logic [4:0]  idx_o;
  logic [15:0] vec_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_resolver u_irq_resolver (
    .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi_req_i), .evt_i(evt_i),
    .irq_mask_i(irq_mask_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .flags_o(flags_o), .valid_o(valid_o),
    .idx_o(idx_o), .vec_o(vec_o)
  );

  function automatic logic [15:0] exp_vec(int idx);
    return 16'(32'hFFFE - 2 * idx);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(logic [14:0] bits);
    evt_i = bits;
    tick();
    evt_i = '0;
  endtask

  task automatic wr(logic a, logic [14:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic check_win(string req, int idx);
    #1;
    check(req, int'(valid_o), 1);
    check(req, int'(idx_o), idx);
    check(req, int'(vec_o), int'(exp_vec(idx)));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    #1;
    check("R9 flags", int'(flags_o), 0);
    check("R10 valid", int'(valid_o), 0);
    check("R10 idx", int'(idx_o), 0);
    check("R10 vec", int'(vec_o), 0);
  endtask

  task automatic t_nmi();
    irq_mask_i = 1'b1;
    nmi_req_i = 3'b110; check_win("R1 trap", 1);
    nmi_req_i = 3'b100; check_win("R1 pin", 2);
    nmi_req_i = 3'b111; check_win("R8 reset vec", 0);
    nmi_req_i = 3'b000;
  endtask

  task automatic t_mask();
    pulse(15'(1 << 5));
    #1;
    check("R7 flag set", int'(flags_o), 32);
    check("R2 masked", int'(valid_o), 0);
    irq_mask_i = 1'b0;
    check_win("R8 maskable vec", 8);
    nmi_req_i = 3'b100;
    check_win("R1 over maskable", 2);
    nmi_req_i = 3'b000;
  endtask

  task automatic t_default();
    pulse(15'((1 << 2) | (1 << 9)));
    check_win("R3 default", 5);
  endtask

  task automatic t_promote();
    irq_mask_i = 1'b1;
    wr(1'b0, 15'd9);
    irq_mask_i = 1'b0;
    check_win("R4 promoted", 12);
    wr(1'b1, 15'(1 << 9));
    #1;
    check("R7 cleared", int'(flags_o), 32'h24);
    check_win("R5 fallback", 5);
  endtask

  task automatic t_sel_lock();
    irq_mask_i = 1'b0;
    wr(1'b0, 15'd5);
    check_win("R6 write while unmasked", 5);
    irq_mask_i = 1'b1;
    wr(1'b0, 15'd15);
    pulse(15'(1 << 9));
    irq_mask_i = 1'b0;
    check_win("R6 bad code", 12);
    irq_mask_i = 1'b1;
    wr(1'b0, 15'd5);
    irq_mask_i = 1'b0;
    check_win("R6 accepted", 8);
  endtask

  task automatic t_flags();
    evt_i = 15'(1 << 0);
    wr(1'b1, 15'(1 << 0));
    evt_i = '0;
    #1;
    check("R7 set beats clear", int'(flags_o[0]), 1);
    tick(); tick(); tick();
    check("R7 persists", int'(flags_o), 32'h225);
    wr(1'b1, 15'h7FFF);
    #1;
    check("R7 clear all", int'(flags_o), 0);
    check("R10 idle", int'(valid_o), 0);
    check("R10 idle vec", int'(vec_o), 0);
  endtask

  task automatic t_reset_sel();
    irq_mask_i = 1'b1;
    wr(1'b0, 15'd14);
    t_reset();
    pulse(15'((1 << 14) | (1 << 1)));
    irq_mask_i = 1'b0;
    check_win("R9 sel reset", 4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_nmi();
    t_mask();
    t_default();
    t_promote();
    t_sel_lock();
    t_flags();
    t_reset_sel();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule